// File: doc/BRIEF.md
# TDM Audio Slot Receiver

This block turns a serial audio data line into parallel samples for up to eight receive channels. It runs directly on the bit clock and samples the data line and the frame clock on each rising edge. A frame is divided into timeslots. Each channel has an enable bit and a 3-bit timeslot number, so the channels can be placed in any order within the frame. Three framing styles are supported: a pulse-framed DSP style, where the slots run back to back from the frame start, and two half-frame styles (I2S and left-justified), where even slots fill the first half-frame and odd slots fill the second.

The configuration inputs set the slot length in bit clocks, the word length in valid bits and the frame length in bit clocks. They are expected to stay stable while the block is out of reset. Each completed word is left-aligned in a 32-bit output and presented with its channel number and a single-cycle valid strobe. A sticky error flag reports a configuration whose enabled slots cannot fit in the programmed frame.

Top module: `tdm_slot_rx`

## Requirements
- R1: Up to 8 receive channels, each with its own enable bit in `ch_en`. A disabled channel never appears on `rx_chan` with `rx_valid` high.
- R2: An enabled channel c takes its sample only from the timeslot held in `ch_slot[3c+2:3c]`. Each enabled channel yields exactly one word per frame.
- R3: Format code 0 (DSP): a frame starts on the rising edge that first sees the frame clock high after it was low. The first bit of slot k is sampled k×slot_len edges after that edge, counting that edge as offset 0.
- R4: Format code 1 (I2S): the half-frame with the frame clock low comes first. The MSB is sampled one bit clock after the edge that sees the frame clock change. Even slot 2k starts at offset k×slot_len in the first half-frame, and odd slot 2k+1 starts at the same offset in the second half-frame.
- R5: Format code 2 (left-justified): the half-frame with the frame clock high comes first. The MSB is sampled on the edge that first sees the frame clock change. Slots are placed as in R4, with no one-bit delay.
- R6: Words arrive MSB first. Slot length and word length are set separately. Data bits in a slot after the first word_len bits have no effect on the output.
- R7: A received word appears on `rx_data` with its MSB at bit 31 and zeros below its LSB. `rx_valid` is high for exactly one cycle, registered on the edge that samples the LSB, and `rx_chan` holds the channel index at the same time.
- R8: Timeslots that no enabled channel uses, and spare bit clocks before a frame clock transition, produce no output.
- R9: `frame_err` is set at a frame start if the configuration cannot fit. This happens when word_len is outside 16..32, when word_len exceeds slot_len, or when an enabled channel's last bit lies beyond the frame. The frame limit is slot×slot_len+word_len ≤ frame_len for DSP and (slot/2)×slot_len+word_len(+1 for I2S) ≤ frame_len/2 for the half-frame formats.
- R10: Once set, `frame_err` stays set until reset, even if the configuration is later corrected.
- R11: While reset is held and right after it, all outputs are zero. The first edge after reset only records the frame clock level and is never treated as a transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; all sampling on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lrclk | input | 1 | Frame clock |
| sdata | input | 1 | Serial receive data |
| fmt | input | 2 | Framing: 0 DSP, 1 I2S, 2 left-justified, 3 no framing |
| slot_len | input | 6 | Bit clocks per timeslot |
| word_len | input | 6 | Valid bits per word (16..32) |
| frame_len | input | 10 | Bit clocks per frame |
| ch_en | input | 8 | Per-channel enable |
| ch_slot | input | 24 | Timeslot of channel c in bits 3c+2..3c |
| rx_data | output | 32 | Left-aligned received word |
| rx_chan | output | 3 | Channel of the word on rx_data |
| rx_valid | output | 1 | One-cycle strobe for a new word |
| frame_err | output | 1 | Sticky frame-fit error |

## Verification
A bit or slot counter that is off by one shows up at the ports within one word. The captured bits shift, so `rx_data` differs from the transmitted sample on the first `rx_valid` of the frame. A wrong half-frame choice or a wrong slot mapping gives a word on the wrong channel, or too many or too few words per channel, by the end of the first frame. An error flag that misjudges the frame fit, or that clears itself, is visible on `frame_err` one edge after the next frame start.

// File: rtl/tdm_slot_rx_pkg.sv
`timescale 1ns/1ps
package tdm_slot_rx_pkg;

  typedef enum logic [1:0] {
    FMT_DSP  = 2'd0,
    FMT_I2S  = 2'd1,
    FMT_LJ   = 2'd2,
    FMT_NONE = 2'd3
  } rx_fmt_e;

  // Global timeslot number from the slot counted inside a frame or half-frame.
  function automatic logic [7:0] ts_of(logic [1:0] fmt, logic [7:0] slot, logic half);
    if (fmt == FMT_DSP) return slot;
    return {slot[6:0], half};
  endfunction

  // Whether a channel's word fits in the frame (or half-frame) it lives in.
  function automatic logic slot_fits(logic [1:0] fmt, logic [15:0] slot, logic [15:0] slen,
                                     logic [15:0] wlen, logic [15:0] flen);
    logic [15:0] need;
    logic [15:0] room;
    if (fmt == FMT_DSP) begin
      need = slot * slen + wlen;
      room = flen;
    end else begin
      need = (slot >> 1) * slen + wlen + ((fmt == FMT_I2S) ? 16'd1 : 16'd0);
      room = flen >> 1;
    end
    return need <= room;
  endfunction

  // Word length must lie within the legal range and inside the slot.
  function automatic logic word_ok(logic [15:0] wlen, logic [15:0] slen, logic [15:0] wmax);
    return (wlen >= 16'd16) && (wlen <= wmax) && (wlen <= slen);
  endfunction

endpackage

// File: rtl/tdm_slot_rx_framer.sv
`timescale 1ns/1ps
module tdm_slot_rx_framer
  import tdm_slot_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lrclk,
  input  logic [1:0] fmt,
  output logic       start,
  output logic       half
);

  logic lr_q;
  logic primed_q;
  logic pend_q;
  logic phalf_q;
  logic edge_now;
  logic pulse_now;

  assign edge_now  = primed_q && (lrclk != lr_q);
  assign pulse_now = primed_q && lrclk && !lr_q;

  always_comb begin
    start = 1'b0;
    half  = 1'b0;
    case (fmt)
      FMT_DSP: begin
        start = pulse_now;
        half  = 1'b0;
      end
      FMT_I2S: begin
        start = pend_q;
        half  = phalf_q;
      end
      FMT_LJ: begin
        start = edge_now;
        half  = ~lrclk;
      end
      default: begin
        start = 1'b0;
        half  = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lr_q     <= 1'b0;
      primed_q <= 1'b0;
      pend_q   <= 1'b0;
      phalf_q  <= 1'b0;
    end else begin
      lr_q     <= lrclk;
      primed_q <= 1'b1;
      pend_q   <= (fmt == FMT_I2S) && edge_now;
      phalf_q  <= lrclk;
    end
  end

endmodule

// File: rtl/tdm_slot_rx_counter.sv
`timescale 1ns/1ps
module tdm_slot_rx_counter #(
  parameter int SL_W = 6,
  parameter int SC_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            half,
  input  logic [SL_W-1:0] slot_len,
  output logic [SL_W-1:0] cur_bit,
  output logic [SC_W-1:0] cur_slot,
  output logic            cur_half,
  output logic            cur_active,
  output logic            slot_wrap
);

  logic [SL_W-1:0] bit_q;
  logic [SC_W-1:0] slot_q;
  logic            half_q;
  logic            active_q;

  assign slot_wrap = active_q && !start &&
                     (({1'b0, bit_q} + {{SL_W{1'b0}}, 1'b1}) >= {1'b0, slot_len});

  always_comb begin
    if (start) begin
      cur_bit    = '0;
      cur_slot   = '0;
      cur_half   = half;
      cur_active = 1'b1;
    end else begin
      cur_half   = half_q;
      cur_active = active_q;
      if (slot_wrap) begin
        cur_bit  = '0;
        cur_slot = (slot_q == {SC_W{1'b1}}) ? slot_q : slot_q + 1'b1;
      end else begin
        cur_bit  = bit_q + 1'b1;
        cur_slot = slot_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q    <= '0;
      slot_q   <= '0;
      half_q   <= 1'b0;
      active_q <= 1'b0;
    end else begin
      bit_q    <= cur_bit;
      slot_q   <= cur_slot;
      half_q   <= cur_half;
      active_q <= cur_active;
    end
  end

endmodule

// File: rtl/tdm_slot_rx_match.sv
`timescale 1ns/1ps
module tdm_slot_rx_match #(
  parameter int NUM_CH = 8,
  parameter int TS_W   = 3,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic                   cur_active,
  input  logic [7:0]             cur_ts,
  input  logic [NUM_CH-1:0]      ch_en,
  input  logic [NUM_CH*TS_W-1:0] ch_slot,
  output logic                   hit,
  output logic [CH_W-1:0]        hit_ch
);

  logic [NUM_CH-1:0] m;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_cmp
    assign m[c] = cur_active && ch_en[c] && (cur_ts == 8'(ch_slot[c*TS_W +: TS_W]));
  end

  assign hit = |m;

  always_comb begin
    hit_ch = '0;
    for (int c = NUM_CH - 1; c >= 0; c--) begin
      if (m[c]) hit_ch = CH_W'(c);
    end
  end

endmodule

// File: rtl/tdm_slot_rx_cfgchk.sv
`timescale 1ns/1ps
module tdm_slot_rx_cfgchk
  import tdm_slot_rx_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int TS_W   = 3,
  parameter int SL_W   = 6,
  parameter int WL_W   = 6,
  parameter int FL_W   = 10,
  parameter int DATA_W = 32
) (
  input  logic [1:0]             fmt,
  input  logic [SL_W-1:0]        slot_len,
  input  logic [WL_W-1:0]        word_len,
  input  logic [FL_W-1:0]        frame_len,
  input  logic [NUM_CH-1:0]      ch_en,
  input  logic [NUM_CH*TS_W-1:0] ch_slot,
  output logic                   cfg_bad
);

  logic [NUM_CH-1:0] viol;
  logic              wl_bad;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_fit
    assign viol[c] = ch_en[c] &&
                     !slot_fits(fmt, 16'(ch_slot[c*TS_W +: TS_W]), 16'(slot_len),
                                16'(word_len), 16'(frame_len));
  end

  assign wl_bad  = !word_ok(16'(word_len), 16'(slot_len), 16'(DATA_W));
  assign cfg_bad = (|viol) || wl_bad;

endmodule

// File: rtl/tdm_slot_rx.sv
`timescale 1ns/1ps
module tdm_slot_rx
  import tdm_slot_rx_pkg::*;
#(
  parameter int NUM_CH    = 8,
  parameter int NUM_SLOTS = 8,
  parameter int DATA_W    = 32,
  parameter int SL_W      = 6,
  parameter int WL_W      = 6,
  parameter int FL_W      = 10,
  localparam int CH_W     = $clog2(NUM_CH),
  localparam int TS_W     = $clog2(NUM_SLOTS),
  localparam int SC_W     = TS_W + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   lrclk,
  input  logic                   sdata,
  input  logic [1:0]             fmt,
  input  logic [SL_W-1:0]        slot_len,
  input  logic [WL_W-1:0]        word_len,
  input  logic [FL_W-1:0]        frame_len,
  input  logic [NUM_CH-1:0]      ch_en,
  input  logic [NUM_CH*TS_W-1:0] ch_slot,
  output logic [DATA_W-1:0]      rx_data,
  output logic [CH_W-1:0]        rx_chan,
  output logic                   rx_valid,
  output logic                   frame_err
);

  logic              frm_start;
  logic              frm_half;
  logic [SL_W-1:0]   cur_bit;
  logic [SC_W-1:0]   cur_slot;
  logic              cur_half;
  logic              cur_active;
  logic              slot_wrap;
  logic [7:0]        cur_ts;
  logic              hit;
  logic [CH_W-1:0]   hit_ch;
  logic              cfg_bad;
  logic              cap_bit;
  logic              cap_last;
  logic [DATA_W-1:0] acc_q;
  logic [DATA_W-1:0] acc_nxt;

  tdm_slot_rx_framer u_framer (
    .clk   (clk),
    .rst_n (rst_n),
    .lrclk (lrclk),
    .fmt   (fmt),
    .start (frm_start),
    .half  (frm_half)
  );

  tdm_slot_rx_counter #(.SL_W(SL_W), .SC_W(SC_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (frm_start),
    .half       (frm_half),
    .slot_len   (slot_len),
    .cur_bit    (cur_bit),
    .cur_slot   (cur_slot),
    .cur_half   (cur_half),
    .cur_active (cur_active),
    .slot_wrap  (slot_wrap)
  );

  assign cur_ts = ts_of(fmt, 8'(cur_slot), cur_half);

  tdm_slot_rx_match #(.NUM_CH(NUM_CH), .TS_W(TS_W)) u_match (
    .cur_active (cur_active),
    .cur_ts     (cur_ts),
    .ch_en      (ch_en),
    .ch_slot    (ch_slot),
    .hit        (hit),
    .hit_ch     (hit_ch)
  );

  tdm_slot_rx_cfgchk #(
    .NUM_CH(NUM_CH), .TS_W(TS_W), .SL_W(SL_W), .WL_W(WL_W), .FL_W(FL_W), .DATA_W(DATA_W)
  ) u_chk (
    .fmt       (fmt),
    .slot_len  (slot_len),
    .word_len  (word_len),
    .frame_len (frame_len),
    .ch_en     (ch_en),
    .ch_slot   (ch_slot),
    .cfg_bad   (cfg_bad)
  );

  // Capture only the first word_len bits of a matched slot.
  assign cap_bit  = hit && (8'(cur_bit) < 8'(word_len)) && (int'(cur_bit) < DATA_W);
  assign cap_last = cap_bit && (8'(cur_bit) == (8'(word_len) - 8'd1));

  always_comb begin
    acc_nxt = (cur_bit == '0) ? '0 : acc_q;
    if (cap_bit) begin
      acc_nxt = acc_nxt | (DATA_W'(sdata) << (DATA_W - 1 - int'(cur_bit)));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q     <= '0;
      rx_data   <= '0;
      rx_chan   <= '0;
      rx_valid  <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      rx_valid <= cap_last;
      if (cap_bit) acc_q <= acc_nxt;
      if (cap_last) begin
        rx_data <= acc_nxt;
        rx_chan <= hit_ch;
      end
      if (frm_start && cfg_bad) frame_err <= 1'b1;
    end
  end

endmodule

// File: rtl/tdm_slot_rx_sva.sv
`timescale 1ns/1ps
module tdm_slot_rx_sva
  import tdm_slot_rx_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int DATA_W = 32,
  parameter int WL_W   = 6,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lrclk,
  input logic [1:0]        fmt,
  input logic [NUM_CH-1:0] ch_en,
  input logic [WL_W-1:0]   word_len,
  input logic [DATA_W-1:0] rx_data,
  input logic [CH_W-1:0]   rx_chan,
  input logic              rx_valid,
  input logic              frame_err,
  input logic              frm_start
);

  logic [NUM_CH-1:0] en_d;
  logic [WL_W-1:0]   wl_d;
  logic [DATA_W:0]   low_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_d <= '0;
      wl_d <= '0;
    end else begin
      en_d <= ch_en;
      wl_d <= word_len;
    end
  end

  assign low_mask = ((DATA_W+1)'(1) << (DATA_W - int'(wl_d))) - (DATA_W+1)'(1);

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid); // R7
  AST_CHAN_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> en_d[rx_chan]); // R1
  AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && int'(wl_d) >= 16 && int'(wl_d) <= DATA_W) |->
      ((rx_data & low_mask[DATA_W-1:0]) == '0)); // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> frame_err); // R10
  AST_ERR_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_err) |-> $past(frm_start)); // R9
  AST_I2S_ONE_BIT_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt == FMT_I2S && frm_start) |-> ($past(lrclk) != $past(lrclk, 2))); // R4

endmodule

bind tdm_slot_rx tdm_slot_rx_sva #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .WL_W(WL_W)) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .lrclk     (lrclk),
  .fmt       (fmt),
  .ch_en     (ch_en),
  .word_len  (word_len),
  .rx_data   (rx_data),
  .rx_chan   (rx_chan),
  .rx_valid  (rx_valid),
  .frame_err (frame_err),
  .frm_start (frm_start)
);

// File: tb/sim_tdm_slot_rx.sv
`timescale 1ns/1ps
module sim_tdm_slot_rx;

  typedef struct packed {
    logic [1:0]  fmt;
    logic [5:0]  sl;
    logic [5:0]  wl;
    logic [9:0]  fl;
    logic [7:0]  en;
    logic [23:0] slots;
    logic        err;
  } vec_t;

  localparam int NV = 9;
  // fmt, slot_len, word_len, frame_len, enables, slot map (octal digit per channel, ch0 lowest), error
  localparam vec_t VEC [NV] = '{
    '{2'd0, 6'd32, 6'd24, 10'd256, 8'hFF, 24'o01234567, 1'b0},
    '{2'd1, 6'd32, 6'd24, 10'd256, 8'hFF, 24'o76543210, 1'b0},
    '{2'd2, 6'd20, 6'd16, 10'd200, 8'hA5, 24'o01234567, 1'b0},
    '{2'd0, 6'd18, 6'd16, 10'd160, 8'h0F, 24'o00003510, 1'b0},
    '{2'd0, 6'd32, 6'd32, 10'd256, 8'h80, 24'o70000000, 1'b0},
    '{2'd0, 6'd32, 6'd32, 10'd250, 8'h80, 24'o70000000, 1'b1},
    '{2'd1, 6'd32, 6'd32, 10'd128, 8'h02, 24'o00000030, 1'b1},
    '{2'd2, 6'd32, 6'd32, 10'd128, 8'h02, 24'o00000030, 1'b0},
    '{2'd0, 6'd12, 6'd16, 10'd256, 8'h01, 24'o00000000, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lrclk = 1'b0;
  logic        sdata = 1'b1;
  logic [1:0]  fmt = 2'd0;
  logic [5:0]  slot_len = 6'd32;
  logic [5:0]  word_len = 6'd24;
  logic [9:0]  frame_len = 10'd256;
  logic [7:0]  ch_en = 8'h00;
  logic [23:0] ch_slot = '0;
  logic [31:0] rx_data;
  logic [2:0]  rx_chan;
  logic        rx_valid;
  logic        frame_err;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [31:0] got [8][4];
  int          got_n [8];

  always #2.5 clk = ~clk;

  tdm_slot_rx u0 (
    .clk(clk), .rst_n(rst_n), .lrclk(lrclk), .sdata(sdata), .fmt(fmt),
    .slot_len(slot_len), .word_len(word_len), .frame_len(frame_len),
    .ch_en(ch_en), .ch_slot(ch_slot), .rx_data(rx_data), .rx_chan(rx_chan),
    .rx_valid(rx_valid), .frame_err(frame_err)
  );

  always @(negedge clk) begin
    if (rst_n && rx_valid) begin
      if (got_n[rx_chan] < 4) got[rx_chan][got_n[rx_chan]] = rx_data;
      got_n[rx_chan] = got_n[rx_chan] + 1;
    end
  end

  function automatic logic [31:0] smp(int c, int f, int v);
    logic [31:0] x;
    x = 32'h9E3779B9 * 32'(c + 1);
    x = x ^ (32'h85EBCA6B * 32'(f + 3));
    x = x ^ 32'(v * 7919) ^ 32'h0000_0001;
    return x;
  endfunction

  function automatic logic [31:0] top_mask(int wl);
    logic [31:0] m;
    m = '1;
    return m << (32 - wl);
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic clear_got();
    for (int c = 0; c < 8; c++) got_n[c] = 0;
  endtask

  task automatic apply_cfg(int v);
    fmt = VEC[v].fmt; slot_len = VEC[v].sl; word_len = VEC[v].wl;
    frame_len = VEC[v].fl; ch_en = VEC[v].en; ch_slot = VEC[v].slots;
  endtask

  // Serialises one frame from the requirement-level placement rules.
  task automatic send_frame(int f, int v);
    bit line [0:1023];
    int fl, hl, sl, wl, s, off;
    logic [31:0] w;
    fl = int'(VEC[v].fl); hl = fl / 2; sl = int'(VEC[v].sl); wl = int'(VEC[v].wl);
    for (int p = 0; p < 1024; p++) line[p] = 1'b1;
    for (int c = 0; c < 8; c++) begin
      if (VEC[v].en[c]) begin
        s = int'(VEC[v].slots[3*c +: 3]);
        w = smp(c, f, v) & top_mask(wl);
        if (VEC[v].fmt == 2'd0) off = s * sl;
        else off = (s % 2) * hl + (s / 2) * sl + ((VEC[v].fmt == 2'd1) ? 1 : 0);
        for (int b = 0; b < wl; b++) if (off + b < fl) line[off + b] = w[31 - b];
      end
    end
    for (int p = 0; p < fl; p++) begin
      @(negedge clk);
      if (VEC[v].fmt == 2'd0) lrclk = (p == 0);
      else if (VEC[v].fmt == 2'd1) lrclk = (p >= hl);
      else lrclk = (p < hl);
      sdata = line[p];
    end
  endtask

  task automatic run_vec(int v);
    string tag;
    bit ok;
    int en_n;
    logic [31:0] e;
    apply_cfg(v);
    rst_n = 1'b0;
    lrclk = (VEC[v].fmt == 2'd1);
    sdata = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    clear_got();
    send_frame(0, v);
    send_frame(1, v);
    @(negedge clk); sdata = 1'b1;
    repeat (40) @(negedge clk);
    check(frame_err == VEC[v].err, $sformatf("R9 vec%0d frame_err", v),
          32'(frame_err), 32'(VEC[v].err));
    if (!VEC[v].err) begin
      case (VEC[v].fmt)
        2'd0: tag = "R2 R3 R6 R7 R8";
        2'd1: tag = "R2 R4 R6 R7 R8";
        default: tag = "R2 R5 R6 R7 R8";
      endcase
      for (int c = 0; c < 8; c++) begin
        en_n = VEC[v].en[c] ? 2 : 0;
        check(got_n[c] == en_n, $sformatf("R1 %s vec%0d ch%0d word count", tag, v, c),
              32'(got_n[c]), 32'(en_n));
        for (int k = 0; k < en_n && k < got_n[c]; k++) begin
          e = smp(c, k, v) & top_mask(int'(VEC[v].wl));
          ok = (got[c][k] == e);
          check(ok, $sformatf("%s vec%0d ch%0d frame%0d data", tag, v, c, k), got[c][k], e);
        end
      end
    end
  endtask

  initial begin
    for (int c = 0; c < 8; c++) got_n[c] = 0;
    // R11: reset state
    repeat (3) @(negedge clk);
    check(rx_valid == 1'b0 && frame_err == 1'b0 && rx_data == '0 && rx_chan == '0,
          "R11 reset outputs", {rx_data[27:0], rx_chan, rx_valid} , 32'h0);

    for (int v = 0; v < NV; v++) run_vec(v);

    // R10: error stays set after the configuration is corrected without reset
    run_vec(5);
    apply_cfg(0);
    clear_got();
    send_frame(0, 0);
    @(negedge clk); sdata = 1'b1;
    repeat (40) @(negedge clk);
    check(frame_err == 1'b1, "R10 frame_err sticky", 32'(frame_err), 32'h1);

    // R11: reset clears the flag; the first edge after reset is not a transition
    rst_n = 1'b0;
    fmt = 2'd2; lrclk = 1'b1; sdata = 1'b1; ch_en = 8'hFF; ch_slot = 24'o76543210;
    repeat (2) @(negedge clk);
    check(frame_err == 1'b0, "R11 reset clears frame_err", 32'(frame_err), 32'h0);
    rst_n = 1'b1;
    clear_got();
    repeat (100) @(negedge clk);
    check(got_n[0] + got_n[2] + got_n[4] + got_n[6] == 0, "R11 no false start after reset",
          32'(got_n[0] + got_n[2] + got_n[4] + got_n[6]), 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule